// File: doc/BRIEF.md
# Hibernate and Wakeup Power Sequencer

This block runs on the always-on 32.768 kHz real-time clock. It lets software power the system down and brings the system back up from an external wake pin. Software first programs a minimum wake-pin hold time and a reset stretch time. It then sets a single hibernate bit, and the block raises its power-off output.

While powered down, the block watches an active-low wake pin through a two-stage synchronizer. A short glitch is ignored: the pin must stay asserted for the programmed number of ticks, and any release before that point starts the count again. Once a wake is accepted, the block clears the hibernate bit and drops power-off. It then holds an active-low system reset for the programmed number of ticks before it returns to normal running.

Both timing values are coarse: each register field counts in units of 32 ticks, and the five low bits always read back as zero.

Top module: `rtc_pwrseq`

## Requirements
- R1: After reset, `pwr_off` is 0, `sys_rst_n` is 1, and the hibernate, filter and stretch registers all read 0.
- R2: Register decode uses these offsets and bits. Offset 0x20 holds the hibernate bit in bit 0. Offset 0x24 holds the wake filter field in bits 15:5. Offset 0x28 holds the reset stretch field in bits 11:5. Any bit outside these fields reads 0 and ignores writes. Any other offset reads 0.
- R3: A write of 1 to bit 0 at offset 0x20 sets the hibernate bit at the edge that accepts the write. `pwr_off` rises one edge later, and the bit reads 1 while the block is powered down. A write with bit 0 cleared leaves `pwr_off` at 0.
- R4: `wake_n` is active low and is sampled through two flops. An assertion driven in cycle c is first seen by the sequencer at the third edge after it.
- R5: Let the filter threshold T be the filter field times 32. A wake is accepted on the (T+1)th consecutive synchronized asserted sample. When the field is 0, the first synchronized sample is accepted.
- R6: If the synchronized pin deasserts before the wake is accepted, the count restarts from zero and `pwr_off` stays 1.
- R7: At the edge that accepts a wake, `pwr_off` falls and the hibernate bit clears. `sys_rst_n` is then low for exactly S cycles, where S is the stretch field times 32, and then returns high. When S is 0, no reset pulse is produced.
- R8: The wake pin has no effect while the block is running; `pwr_off` and `sys_rst_n` stay deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on RTC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wake_n | input | 1 | Active-low wake pin, asynchronous |
| pwr_off | output | 1 | High while the system is powered down |
| sys_rst_n | output | 1 | Active-low system reset after wakeup |

## Verification
Suppose the filter counter keeps a stale count, or fails to restart after a glitch. The port symptom is that `pwr_off` falls before the (T+1)th clean sample, so the bench samples `pwr_off` in the cycle just before acceptance and in the cycle of acceptance. A wrong stretch count shows up as `sys_rst_n` rising one or more cycles early or late; the bench checks the first low cycle, the last low cycle and the first high cycle. If the hibernate bit fails to clear, the readback at offset 0x20 after wakeup shows it. If the sequencer reacts to the pin while running, `pwr_off` rises within three cycles of the pin falling.

// File: rtl/rtc_pwrseq_pkg.sv
package rtc_pwrseq_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_FILT  = 2'd2,
    PS_HOLD  = 2'd3
  } pseq_state_e;
endpackage

// File: rtl/rtc_pwrseq_sync.sv
module rtc_pwrseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic active
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Stage 0 captures the inverted pin; each later stage copies the one before it.
  always_comb begin
    chain_d[0] = ~pin_n;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign active = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_pwrseq_regs.sv
module rtc_pwrseq_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FLD_LO   = 5,
  parameter int unsigned FILT_HI  = 15,
  parameter int unsigned RST_HI   = 11,
  parameter int unsigned OFF_HIB  = 32'h20,
  parameter int unsigned OFF_FILT = 32'h24,
  parameter int unsigned OFF_RST  = 32'h28,
  localparam int unsigned CNT_W   = FILT_HI + 1,
  localparam int unsigned FW      = FILT_HI - FLD_LO + 1,
  localparam int unsigned RW      = RST_HI - FLD_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake_take,
  output logic [DATA_W-1:0] rdata,
  output logic              hib_q,
  output logic [CNT_W-1:0]  filt_ticks,
  output logic [CNT_W-1:0]  rst_ticks
);
  logic          hit_hib, hit_filt, hit_rst;
  logic          hib_en, filt_en, rst_en;
  logic          hib_d;
  logic [FW-1:0] filt_q, filt_d;
  logic [RW-1:0] rstf_q, rstf_d;
  logic          unused_wdata;

  assign hit_hib  = (addr == ADDR_W'(OFF_HIB));
  assign hit_filt = (addr == ADDR_W'(OFF_FILT));
  assign hit_rst  = (addr == ADDR_W'(OFF_RST));
  assign unused_wdata = ^{wdata[DATA_W-1:FILT_HI+1], wdata[FLD_LO-1:1]};

  // Next-state logic; an accepted wake takes priority over a hibernate write.
  always_comb begin
    hib_en  = (wr_en && hit_hib) || wake_take;
    hib_d   = wake_take ? 1'b0 : wdata[0];
    filt_en = wr_en && hit_filt;
    filt_d  = wdata[FILT_HI:FLD_LO];
    rst_en  = wr_en && hit_rst;
    rstf_d  = wdata[RST_HI:FLD_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hib_q  <= 1'b0;
      filt_q <= '0;
      rstf_q <= '0;
    end else begin
      if (hib_en)  hib_q  <= hib_d;
      if (filt_en) filt_q <= filt_d;
      if (rst_en)  rstf_q <= rstf_d;
    end
  end

  assign filt_ticks = {filt_q, {FLD_LO{1'b0}}};
  assign rst_ticks  = CNT_W'({rstf_q, {FLD_LO{1'b0}}});

  always_comb begin
    rdata = '0;
    if (hit_hib)  rdata[0] = hib_q;
    if (hit_filt) rdata[FILT_HI:FLD_LO] = filt_q;
    if (hit_rst)  rdata[RST_HI:FLD_LO] = rstf_q;
  end

  // R2
  filt_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && hit_filt) && hit_filt) |-> (rdata[FILT_HI:FLD_LO] == $past(wdata[FILT_HI:FLD_LO])));

  // R2
  rst_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && hit_rst) && hit_rst) |-> (rdata == DATA_W'({$past(wdata[RST_HI:FLD_LO]), {FLD_LO{1'b0}}})));
endmodule

// File: rtl/rtc_pwrseq_fsm.sv
module rtc_pwrseq_fsm
  import rtc_pwrseq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hib_q,
  input  logic             wake_act,
  input  logic [CNT_W-1:0] filt_ticks,
  input  logic [CNT_W-1:0] rst_ticks,
  output logic             pwr_off,
  output logic             sys_rst_n,
  output logic             wake_take
);
  pseq_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    wake_take = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (hib_q) st_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (wake_act) begin
          if (filt_ticks == '0) wake_take = 1'b1;
          else begin
            st_d   = PS_FILT;
            cnt_en = 1'b1;
            cnt_d  = CNT_W'(1);
          end
        end
      end
      PS_FILT: begin
        cnt_en = 1'b1;
        if (!wake_act) begin
          st_d  = PS_SLEEP;
          cnt_d = '0;
        end else if (cnt_q == filt_ticks) begin
          wake_take = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PS_HOLD: begin
        cnt_en = 1'b1;
        if (cnt_q == rst_ticks) begin
          st_d  = PS_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = PS_RUN;
    endcase
    // Leaving power-off: stretch reset unless the stretch count is zero.
    if (wake_take) begin
      cnt_en = 1'b1;
      if (rst_ticks == '0) begin
        st_d  = PS_RUN;
        cnt_d = '0;
      end else begin
        st_d  = PS_HOLD;
        cnt_d = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_RUN;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pwr_off   = (st_q == PS_SLEEP) || (st_q == PS_FILT);
  assign sys_rst_n = (st_q != PS_HOLD);

  // R6
  filt_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_FILT && !wake_act) |=> (st_q == PS_SLEEP));

  // R7
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HOLD) |-> (cnt_q != '0 && cnt_q <= rst_ticks));

  // R8
  run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !hib_q) |=> (st_q == PS_RUN));
endmodule

// File: rtl/rtc_pwrseq.sv
module rtc_pwrseq #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FLD_LO   = 5,
  parameter int unsigned FILT_HI  = 15,
  parameter int unsigned RST_HI   = 11,
  parameter int unsigned SYNC_N   = 2,
  localparam int unsigned CNT_W   = FILT_HI + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake_n,
  output logic              pwr_off,
  output logic              sys_rst_n
);
  logic             hib_q, wake_act, wake_take;
  logic [CNT_W-1:0] filt_ticks, rst_ticks;

  rtc_pwrseq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLD_LO(FLD_LO),
    .FILT_HI(FILT_HI), .RST_HI(RST_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .wake_take(wake_take), .rdata(bus_rdata),
    .hib_q(hib_q), .filt_ticks(filt_ticks), .rst_ticks(rst_ticks)
  );

  rtc_pwrseq_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(wake_n), .active(wake_act)
  );

  rtc_pwrseq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hib_q(hib_q), .wake_act(wake_act),
    .filt_ticks(filt_ticks), .rst_ticks(rst_ticks),
    .pwr_off(pwr_off), .sys_rst_n(sys_rst_n), .wake_take(wake_take)
  );

  // R3
  pwr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_off) |-> hib_q);

  // R7
  hib_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_off) |-> !hib_q);
endmodule

// File: tb/rtc_pwrseq_test.sv
module rtc_pwrseq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wake_n;
  logic        pwr_off;
  logic        sys_rst_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  // kind: 0 = pwr_off, 1 = sys_rst_n, 2 = bus_rdata
  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  rtc_pwrseq uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_n(wake_n),
    .pwr_off(pwr_off), .sys_rst_n(sys_rst_n)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every expectation due in this cycle, away from the edge.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        logic [31:0] act;
        act = (sb[i].kind == 0) ? {31'd0, pwr_off} :
              (sb[i].kind == 1) ? {31'd0, sys_rst_n} : bus_rdata;
        checks++;
        if (sb[i].due != cyc || act !== sb[i].exp) begin
          failures++;
          $display("FAIL %s cycle %0d kind %0d actual=%h expected=%h",
                   sb[i].tag, sb[i].due, sb[i].kind, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int due, int kind, logic [31:0] exp, string tag);
    sb.push_back('{due, kind, exp, tag});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    expect_at(cyc, 2, exp, tag);
    step();
  endtask

  initial begin
    int w, c, c2, c3;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; wake_n = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    expect_at(cyc, 0, 32'd0, "R1");
    expect_at(cyc, 1, 32'd1, "R1");
    rd(8'h20, 32'd0, "R1");
    rd(8'h24, 32'd0, "R1");
    rd(8'h28, 32'd0, "R1");

    // R2 field masking and decode
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0000_FFE0, "R2");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'h0000_0FE0, "R2");
    rd(8'h2C, 32'd0, "R2");
    // R3 a write with bit 0 clear does nothing
    wr(8'h20, 32'hFFFF_FFFE);
    rd(8'h20, 32'd0, "R3");
    expect_at(cyc + 2, 0, 32'd0, "R3");
    step(); step(); step();

    // filter T = 32, stretch S = 64
    wr(8'h24, 32'h0000_0020);
    wr(8'h28, 32'h0000_0040);

    // R3 entering power-off
    w = cyc;
    expect_at(w + 1, 0, 32'd0, "R3");
    expect_at(w + 2, 0, 32'd1, "R3");
    wr(8'h20, 32'd1);
    step();
    rd(8'h20, 32'd1, "R3");

    // R6 a 20-cycle pulse is rejected and the count restarts
    c = cyc;
    expect_at(c + 5, 0, 32'd1, "R6");
    expect_at(c + 22, 0, 32'd1, "R6");
    expect_at(c + 40, 0, 32'd1, "R6");
    wake_n = 1'b0;
    repeat (20) step();
    wake_n = 1'b1;
    repeat (30) step();

    // R5 and R7 accepted wake, then stretched reset
    c2 = cyc;
    expect_at(c2 + 34, 0, 32'd1, "R5");
    expect_at(c2 + 35, 0, 32'd0, "R5");
    expect_at(c2 + 34, 1, 32'd1, "R7");
    expect_at(c2 + 35, 1, 32'd0, "R7");
    expect_at(c2 + 35 + 63, 1, 32'd0, "R7");
    expect_at(c2 + 35 + 64, 1, 32'd1, "R7");
    wake_n = 1'b0;
    repeat (110) step();
    rd(8'h20, 32'd0, "R7");

    // R8 pin still held low while running
    expect_at(cyc, 0, 32'd0, "R8");
    expect_at(cyc + 10, 0, 32'd0, "R8");
    expect_at(cyc + 10, 1, 32'd1, "R8");
    repeat (12) step();
    wake_n = 1'b1;
    repeat (5) step();

    // R5 zero filter, R7 zero stretch, R4 synchronizer latency
    wr(8'h24, 32'd0);
    wr(8'h28, 32'd0);
    wr(8'h20, 32'd1);
    repeat (3) step();
    c3 = cyc;
    expect_at(c3 + 2, 0, 32'd1, "R4");
    expect_at(c3 + 3, 0, 32'd0, "R5");
    expect_at(c3 + 3, 1, 32'd1, "R7");
    expect_at(c3 + 4, 1, 32'd1, "R7");
    wake_n = 1'b0;
    repeat (8) step();
    wake_n = 1'b1;
    rd(8'h20, 32'd0, "R7");

    repeat (4) step();
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard has %0d unchecked items actual=%0d expected=0", sb.size(), sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule